// File: doc/BRIEF.md
# Instruction Stream Detector and Cache

This block watches the retiring program counter of a processor and divides execution into instruction streams. A stream is a run of addresses that each sit exactly 4 above the one before. A stream ends at the first address that breaks this step, or when its length reaches the largest value one byte can hold. Each finished stream becomes a descriptor made of its start address and its length. The descriptor waits in a short queue, and a set-associative stream cache then looks it up.

A hit puts a short index, the set and way of the matching entry, on the index channel. A miss puts the reserved index 0 on the index channel and the whole descriptor on the miss channel in the same cycle. The block then installs the descriptor in the cache. A trace collector can rebuild the full address trace from these two channels. A flush input, used on a task switch, closes the open stream and empties the cache.

Top module: `istream_cache`

## Requirements
- R1: While `pc_valid_i` is high, an address equal to the previous address plus 4 extends the open stream by one. Any other address closes the open stream with descriptor (start, length) and opens a new stream of length 1 at that address. The very first address after reset or flush opens a stream and closes nothing.
- R2: A stream whose length has reached 255 closes on the next valid address, even if that address is sequential. No descriptor ever has length 0 or more than 255.
- R3: The set of a descriptor is the low log2(SETS) bits of start[log2(SETS*WAYS)+5:6] XOR length. With the defaults this is start[10:6] XOR length[4:0].
- R4: On a hit, `idx_valid_o` pulses for one cycle with `idx_o` = {set, way}, where the set is in the upper bits and the way in the lower log2(WAYS) bits. `miss_valid_o` stays low.
- R5: On a miss, `idx_valid_o` and `miss_valid_o` pulse together. `idx_o` is 0, and `miss_addr_o`/`miss_len_o` carry the descriptor. The descriptor is then installed, so the same stream hits on its next lookup.
- R6: Way 0 of set 0 is never allocated, so `idx_o` = 0 always marks a miss.
- R7: A miss fills the lowest-numbered free way of its set. If no way is free, it evicts the least recently used way, where a hit or a fill counts as a use.
- R8: A hit occupies the lookup engine for one cycle and a miss for two. Descriptors are reported in the order their streams closed, and the cycle after a miss report carries no report.
- R9: `flush_i` closes the open stream and invalidates every cache entry in the same cycle. The descriptor it closes, and any later one, is looked up against the empty cache.
- R10: During and right after the active-low reset, neither output channel is valid.
- R11: The descriptor queue holds FIFO_DEPTH entries (at least 2). It is never written while full unless it is read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_valid_i | input | 1 | A retired instruction address is present |
| pc_i | input | ADDR_W | Retired instruction address |
| flush_i | input | 1 | Task switch: close the open stream and invalidate the cache |
| idx_valid_o | output | 1 | Index channel valid |
| idx_o | output | log2(SETS)+log2(WAYS) | {set, way} on a hit, 0 on a miss |
| miss_valid_o | output | 1 | Miss channel valid |
| miss_addr_o | output | ADDR_W | Start address of the missed stream |
| miss_len_o | output | LEN_W | Length of the missed stream |

## Verification
The assertions check, on every cycle, the invariants that do not depend on history. Index 0 appears exactly when a miss descriptor appears. The reserved entry is never filled. At most one way matches. The lengths stay in range. A flush leaves no valid entry. A miss report is followed by an idle cycle. The queue never overflows. Only the bench scenarios can show that the right descriptors come out, that the set hash and the LRU choices are correct, that evicted streams miss again, and that a stream closed by a flush misses. The bench shows this by replaying stream sequences against a model built from the requirements.

// File: rtl/istream_pkg.sv
package istream_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_LEN_W  = 8;
  localparam int unsigned PC_STEP    = 4;

  typedef enum logic {PH_READY, PH_FILL} lk_phase_e;
endpackage

// File: rtl/istream_detector.sv
module istream_detector import istream_pkg::*; #(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LEN_W  = DEF_LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              flush_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [LEN_W-1:0]  push_len_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = '1;

  logic              active_q;
  logic [ADDR_W-1:0] prev_q, start_q;
  logic [LEN_W-1:0]  len_q;
  logic              seq, at_cap, close_c;

  assign seq     = (pc_i == prev_q + ADDR_W'(PC_STEP));
  assign at_cap  = (len_q == MAX_LEN);
  assign close_c = active_q && (flush_i || (pc_valid_i && (!seq || at_cap)));

  assign push_o      = close_c;
  assign push_addr_o = start_q;
  assign push_len_o  = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      prev_q   <= '0;
      start_q  <= '0;
      len_q    <= '0;
    end else if (pc_valid_i) begin
      prev_q   <= pc_i;
      active_q <= 1'b1;
      if (!active_q || close_c) begin
        start_q <= pc_i;
        len_q   <= LEN_W'(1);
      end else begin
        len_q <= len_q + LEN_W'(1);
      end
    end else if (flush_i) begin
      active_q <= 1'b0;
    end
  end

  assert_len_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (len_q != '0));

  assert_len_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && pc_valid_i && !flush_i && !push_o) |=> (len_q == $past(len_q) + LEN_W'(1)));
endmodule

// File: rtl/istream_fifo.sv
module istream_fifo #(
  parameter int unsigned W     = 40,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (!full || do_pop);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |-> pop_i);
endmodule

// File: rtl/istream_lookup.sv
module istream_lookup import istream_pkg::*; #(
  parameter int unsigned SETS   = 32,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LEN_W  = DEF_LEN_W,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = SET_W + WAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_pop_o,
  output logic              idx_valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  output logic [LEN_W-1:0]  miss_len_o
);
  logic [ADDR_W-1:0] tag_a_q [SETS][WAYS];
  logic [LEN_W-1:0]  tag_l_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q   [SETS];
  logic [WAY_W-1:0]  age_q   [SETS][WAYS];

  lk_phase_e         ph_q;
  logic [SET_W-1:0]  fill_set_q;
  logic [WAY_W-1:0]  fill_way_q;
  logic [ADDR_W-1:0] fill_a_q;
  logic [LEN_W-1:0]  fill_l_q;

  logic [SET_W-1:0]  lk_set;
  logic [WAYS-1:0]   hit_vec;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, vic_way;
  logic              pop, filling;
  logic              touch_en;
  logic [SET_W-1:0]  touch_set;
  logic [WAY_W-1:0]  touch_way, touch_age;
  logic              any_valid;

  // low SET_W bits of the full index-width hash
  assign lk_set = req_addr_i[SET_W+5:6] ^ SET_W'(req_len_i);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_set][w] &&
                        (tag_a_q[lk_set][w] == req_addr_i) &&
                        (tag_l_q[lk_set][w] == req_len_i);
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // free way first (lowest index), else oldest; set 0 way 0 is reserved
  always_comb begin
    logic             found;
    logic [WAY_W-1:0] best;
    found   = 1'b0;
    best    = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!(lk_set == '0 && w == 0) && !vld_q[lk_set][w] && !found) begin
        vic_way = WAY_W'(w);
        found   = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!(lk_set == '0 && w == 0) && age_q[lk_set][w] >= best) begin
          vic_way = WAY_W'(w);
          best    = age_q[lk_set][w];
        end
      end
    end
  end

  assign filling   = (ph_q == PH_FILL) && !flush_i;
  assign pop       = req_valid_i && (ph_q == PH_READY) && !flush_i;
  assign req_pop_o = pop;

  assign touch_en  = (pop && hit) || filling;
  assign touch_set = (ph_q == PH_FILL) ? fill_set_q : lk_set;
  assign touch_way = (ph_q == PH_FILL) ? fill_way_q : hit_way;
  assign touch_age = age_q[touch_set][touch_way];

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q         <= PH_READY;
      idx_valid_o  <= 1'b0;
      idx_o        <= '0;
      miss_valid_o <= 1'b0;
      miss_addr_o  <= '0;
      miss_len_o   <= '0;
      fill_set_q   <= '0;
      fill_way_q   <= '0;
      fill_a_q     <= '0;
      fill_l_q     <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      idx_valid_o  <= pop;
      miss_valid_o <= pop && !hit;
      ph_q         <= (pop && !hit) ? PH_FILL : PH_READY;
      if (pop) begin
        idx_o       <= hit ? {lk_set, hit_way} : '0;
        miss_addr_o <= req_addr_i;
        miss_len_o  <= req_len_i;
        fill_set_q  <= lk_set;
        fill_way_q  <= vic_way;
        fill_a_q    <= req_addr_i;
        fill_l_q    <= req_len_i;
      end
      if (flush_i) begin
        for (int s = 0; s < SETS; s++) begin
          vld_q[s] <= '0;
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end
      end else begin
        if (filling) vld_q[fill_set_q][fill_way_q] <= 1'b1;
        if (touch_en) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
              age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < touch_age)
              age_q[touch_set][w] <= age_q[touch_set][w] + WAY_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (filling) begin
      tag_a_q[fill_set_q][fill_way_q] <= fill_a_q;
      tag_l_q[fill_set_q][fill_way_q] <= fill_l_q;
    end
  end

  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_zero_means_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_o |-> ((idx_o == '0) == miss_valid_o));

  assert_miss_with_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> idx_valid_o);

  assert_miss_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |=> !idx_valid_o);

  assert_no_reserved_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filling |-> (fill_set_q != '0 || fill_way_q != '0));

  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_valid);
endmodule

// File: rtl/istream_cache.sv
module istream_cache import istream_pkg::*; #(
  parameter int unsigned SETS       = 32,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned FIFO_DEPTH = 2,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned LEN_W      = DEF_LEN_W,
  localparam int unsigned IDX_W     = $clog2(SETS) + $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              flush_i,
  output logic              idx_valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  output logic [LEN_W-1:0]  miss_len_o
);
  localparam int unsigned DESC_W = ADDR_W + LEN_W;

  logic              det_push;
  logic [ADDR_W-1:0] det_addr;
  logic [LEN_W-1:0]  det_len;
  logic              q_valid, q_pop;
  logic [DESC_W-1:0] q_data;

  istream_detector #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_valid_i  (pc_valid_i),
    .pc_i        (pc_i),
    .flush_i     (flush_i),
    .push_o      (det_push),
    .push_addr_o (det_addr),
    .push_len_o  (det_len)
  );

  istream_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (det_push),
    .push_data_i ({det_addr, det_len}),
    .pop_i       (q_pop),
    .valid_o     (q_valid),
    .data_o      (q_data)
  );

  istream_lookup #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_lk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .req_valid_i  (q_valid),
    .req_addr_i   (q_data[DESC_W-1:LEN_W]),
    .req_len_i    (q_data[LEN_W-1:0]),
    .req_pop_o    (q_pop),
    .idx_valid_o  (idx_valid_o),
    .idx_o        (idx_o),
    .miss_valid_o (miss_valid_o),
    .miss_addr_o  (miss_addr_o),
    .miss_len_o   (miss_len_o)
  );
endmodule

// File: tb/istream_cache_test.sv
module istream_cache_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pc_valid_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        flush_i = 1'b0;
  logic        idx_valid_o, miss_valid_o;
  logic [6:0]  idx_o;
  logic [31:0] miss_addr_o;
  logic [7:0]  miss_len_o;

  always #10 clk_i = ~clk_i;

  istream_cache uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_valid_i(pc_valid_i), .pc_i(pc_i),
    .flush_i(flush_i), .idx_valid_o(idx_valid_o), .idx_o(idx_o),
    .miss_valid_o(miss_valid_o), .miss_addr_o(miss_addr_o), .miss_len_o(miss_len_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int out_times[$];

  typedef struct {bit miss; logic [6:0] idx; logic [31:0] a; logic [7:0] l; int want;} exp_t;
  exp_t expq[$];

  // reference state built from R1..R7
  bit          mv   [32][4];
  logic [31:0] ma   [32][4];
  logic [7:0]  ml   [32][4];
  int          mage [32][4];
  bit          b_active = 0;
  logic [31:0] b_prev, b_start;
  int          b_len;
  int          b_want, next_want;

  // {start, length, 1 = expected hit}
  localparam logic [40:0] TBL [22] = '{
    {32'h0000_1000, 8'd3, 1'b0}, {32'h0000_2040, 8'd2, 1'b0},
    {32'h0000_1000, 8'd3, 1'b1}, {32'h0000_2040, 8'd2, 1'b1},
    {32'h0000_1000, 8'd4, 1'b0}, {32'h0000_3000, 8'd1, 1'b0},
    {32'h0000_1000, 8'd3, 1'b1}, {32'h0000_2040, 8'd2, 1'b1},
    {32'h0001_0180, 8'd1, 1'b0}, {32'h0002_0180, 8'd1, 1'b0},
    {32'h0003_0180, 8'd1, 1'b0}, {32'h0004_0180, 8'd1, 1'b0},
    {32'h0001_0180, 8'd1, 1'b1}, {32'h0005_0180, 8'd1, 1'b0},
    {32'h0004_0180, 8'd1, 1'b1}, {32'h0002_0180, 8'd1, 1'b0},
    {32'h0001_0040, 8'd1, 1'b0}, {32'h0002_0040, 8'd1, 1'b0},
    {32'h0003_0040, 8'd1, 1'b0}, {32'h0004_0040, 8'd1, 1'b0},
    {32'h0002_0040, 8'd1, 1'b1}, {32'h0001_0040, 8'd1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mage[s][w] = w; end
  endtask

  task automatic touch(input int s, input int w);
    int old;
    old = mage[s][w];
    for (int x = 0; x < 4; x++)
      if (x == w) mage[s][x] = 0;
      else if (mage[s][x] < old) mage[s][x]++;
  endtask

  task automatic model_lookup(input logic [31:0] a, input logic [7:0] l, input int want);
    exp_t e;
    int s, hw, v, best;
    logic [6:0] h;
    h  = a[12:6] ^ l[6:0];            // R3
    s  = int'(h[4:0]);
    hw = -1;
    for (int w = 0; w < 4; w++) if (mv[s][w] && ma[s][w] == a && ml[s][w] == l) hw = w;
    e.a = a; e.l = l; e.want = want;
    if (hw >= 0) begin
      e.miss = 0; e.idx = 7'(s * 4 + hw); touch(s, hw);
    end else begin
      v = -1;
      for (int w = 0; w < 4; w++) if (!(s == 0 && w == 0) && !mv[s][w] && v < 0) v = w;
      if (v < 0) begin
        best = -1;
        for (int w = 0; w < 4; w++)
          if (!(s == 0 && w == 0) && mage[s][w] > best) begin best = mage[s][w]; v = w; end
      end
      mv[s][v] = 1; ma[s][v] = a; ml[s][v] = l; touch(s, v);
      e.miss = 1; e.idx = '0;
    end
    expq.push_back(e);
  endtask

  task automatic model_pc(input logic [31:0] pc);
    if (!b_active) begin
      b_start = pc; b_len = 1; b_want = next_want;
    end else if (pc != b_prev + 32'd4 || b_len == 255) begin
      model_lookup(b_start, 8'(b_len), b_want);
      b_start = pc; b_len = 1; b_want = next_want;
    end else b_len++;
    b_prev = pc; b_active = 1;
  endtask

  task automatic drive_pc(input logic [31:0] pc, input bit gap);
    @(negedge clk_i);
    pc_valid_i = 1'b1; pc_i = pc;
    model_pc(pc);
    @(posedge clk_i); #1;
    pc_valid_i = 1'b0;
    if (gap) @(posedge clk_i);
  endtask

  task automatic do_flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    model_reset();
    if (b_active) model_lookup(b_start, 8'(b_len), b_want);
    b_active = 0;
    @(posedge clk_i); #1;
    flush_i = 1'b0;
  endtask

  task automatic drain();
    repeat (12) @(posedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // output monitor, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (miss_valid_o && !idx_valid_o)
        check(0, "R5", "miss without index", 1, 0);
      if (idx_valid_o) begin
        out_times.push_back(cyc);
        if (expq.size() == 0) begin
          check(0, "R8", "unexpected report idx", 64'(idx_o), 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(miss_valid_o == e.miss, e.miss ? "R5" : "R4", "miss flag",
                64'(miss_valid_o), 64'(e.miss));
          check(idx_o == e.idx, e.miss ? "R6" : "R4", "index", 64'(idx_o), 64'(e.idx));
          if (e.miss) begin
            check(miss_addr_o == e.a, "R1", "miss start", 64'(miss_addr_o), 64'(e.a));
            check(miss_len_o == e.l, "R2", "miss length", 64'(miss_len_o), 64'(e.l));
          end
          if (e.want != 2)
            check(miss_valid_o == (e.want == 0), "R7", "table hit/miss",
                  64'(miss_valid_o), 64'(e.want == 0));
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    next_want = 2;
    repeat (3) @(posedge clk_i);
    #1;
    check(!idx_valid_o && !miss_valid_o, "R10", "outputs in reset",
          64'({idx_valid_o, miss_valid_o}), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(!idx_valid_o && !miss_valid_o, "R10", "outputs after reset",
          64'({idx_valid_o, miss_valid_o}), 0);

    // table walk: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < 22; i++) begin
      logic [31:0] sa;
      int ln;
      sa = TBL[i][40:9]; ln = int'(TBL[i][8:1]);
      next_want = TBL[i][0] ? 1 : 0;
      for (int k = 0; k < ln; k++) drive_pc(sa + 32'(4 * k), 1'b1);
    end
    drain();

    // R9: flush closes the open stream; afterwards a known stream misses
    do_flush();
    drain();
    next_want = 0;
    for (int k = 0; k < 3; k++) drive_pc(32'h0000_1000 + 32'(4 * k), 1'b1);
    next_want = 2;
    drive_pc(32'h0000_5000, 1'b1);
    drain();

    // R8: three streams close on back-to-back cycles, all miss
    out_times.delete();
    drive_pc(32'h0000_A000, 1'b0);
    drive_pc(32'h0000_B000, 1'b0);
    drive_pc(32'h0000_C000, 1'b1);
    drain();
    check(out_times.size() == 3, "R8", "report count", 64'(out_times.size()), 3);
    if (out_times.size() == 3) begin
      check(out_times[1] - out_times[0] == 2, "R8", "miss spacing",
            64'(out_times[1] - out_times[0]), 2);
      check(out_times[2] - out_times[1] == 2, "R8", "miss spacing",
            64'(out_times[2] - out_times[1]), 2);
    end

    // R2: 256 sequential addresses split at length 255
    for (int k = 0; k < 256; k++) drive_pc(32'h0000_8000 + 32'(4 * k), 1'b1);
    drive_pc(32'h0000_9000, 1'b1);
    do_flush();
    drain();

    check(expq.size() == 0, "R8", "pending reports", 64'(expq.size()), 0);
    summary();
    $finish;
  end
endmodule